// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits behind an error-correction stage and turns its byte stream into a parallel transport-stream output. Each packet is 204 bytes long: 188 payload bytes and then 16 parity bytes. The upstream stage presents one byte per `in_valid` strobe. The first byte of a packet carries `in_sop`, and `in_uncor` tells whether the decoder gave up on that packet. The block registers each byte and drives the following outputs, all aligned to the byte they describe:

- a byte clock,
- a payload-enable strobe,
- an uncorrectable-packet flag,
- a sync strobe,
- a lock indicator.

Static control inputs set the polarity of every strobe and of the byte clock. A select input puts either the packet-sync strobe or a multiframe-start strobe on the sync pin. The multiframe-start strobe marks a packet that begins with the inverted sync value 0xB8, which normally appears once every eight packets. The block also watches the spacing of those inverted sync bytes and raises a non-compliance flag when the spacing is wrong.

Top module: `ts_out_fmt`

## Requirements
- R1: Every byte accepted with `in_valid` high appears on `out_data` after the next rising clock edge. `out_data` holds that byte until the next accepted byte.
- R2: With `inv_den` low, `out_den` is high for byte positions 0 to 187 of a packet and low for positions 188 to 203. Position 0 is the byte that carries `in_sop`.
- R3: With `sync_sel` high and `inv_sync` low, `out_sync` is high for the byte at position 0 and low for the other 203 bytes.
- R4: `in_uncor` is sampled on the start-of-packet byte and applies to the whole packet. With `inv_uncor` low, `out_uncor` is high for positions 0 to 187 of an uncorrectable packet and low otherwise. It is low for all 204 bytes of a correctable packet.
- R5: A high level on `inv_den`, `inv_uncor`, `inv_sync` or `inv_lock` inverts only its own output. With `inv_uncor` high, a correctable packet holds `out_uncor` high for all 204 bytes.
- R6: With `sync_sel` low, `out_sync` (before `inv_sync`) is high only for the position-0 byte of a packet whose first byte is 0xB8. It stays low for a packet that starts with 0x47.
- R7: `out_lock` equals `carrier_lock AND frame_sync` registered by one clock, then XOR `inv_lock`.
- R8: When bytes arrive every other clock, `out_clk` (before `inv_clk`) is high in the first cycle of each output byte and low in the second, so its falling edge falls mid-byte. With `inv_clk` high the levels swap and the rising edge falls mid-byte.
- R9: Once a packet starting with 0xB8 has been seen, `non_compliant` is set when one of these happens:
  - a 0xB8 start byte arrives with fewer or more than seven packets since the previous one;
  - the eighth packet after the previous 0xB8 starts with any other value.

  A 0xB8 start byte exactly eight packets after the previous one clears the flag.
- R10: A start-of-packet byte restarts the position count at 0, even when it arrives in the middle of a packet.
- R11: After reset, every strobe sits at its inactive level for the current polarity and `non_compliant` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_data | input | 8 | Input byte |
| in_uncor | input | 1 | Packet is uncorrectable (sampled at start of packet) |
| carrier_lock | input | 1 | Carrier recovery locked |
| frame_sync | input | 1 | Frame synchronization achieved |
| sync_sel | input | 1 | 1: packet sync on sync pin, 0: multiframe start |
| inv_den | input | 1 | Invert payload-enable strobe |
| inv_uncor | input | 1 | Invert uncorrectable flag |
| inv_sync | input | 1 | Invert sync strobe |
| inv_lock | input | 1 | Invert lock indicator |
| inv_clk | input | 1 | Invert byte clock |
| out_data | output | 8 | Output byte |
| out_clk | output | 1 | Output byte clock |
| out_den | output | 1 | Payload-enable strobe |
| out_uncor | output | 1 | Uncorrectable-packet flag |
| out_sync | output | 1 | Packet-sync or multiframe-start strobe |
| out_lock | output | 1 | Front-end lock indicator |
| non_compliant | output | 1 | Multiframe spacing violated |

## Verification
The assertions assume that `in_valid` never arrives on two consecutive cycles, so every output byte lasts at least two clocks. The byte-clock pulse property depends on this. They also assume that every packet opens with a start-of-packet strobe before its payload is counted.

The stimulus drives each byte on a falling edge and drops `in_valid` on the following falling edge. Bytes are therefore spaced exactly two cycles apart. Packets are always started with `in_sop`, except in the one scenario that deliberately cuts a packet short to exercise the restart of the position count.

// File: rtl/ts_out_fmt.sv
module ts_out_fmt #(
  parameter int PKT_LEN   = 204,
  parameter int PAY_LEN   = 188,
  parameter int MF_PERIOD = 8,
  parameter logic [7:0] MF_BYTE = 8'hB8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic [7:0] in_data,
  input  logic       in_uncor,
  input  logic       carrier_lock,
  input  logic       frame_sync,
  input  logic       sync_sel,
  input  logic       inv_den,
  input  logic       inv_uncor,
  input  logic       inv_sync,
  input  logic       inv_lock,
  input  logic       inv_clk,
  output logic [7:0] out_data,
  output logic       out_clk,
  output logic       out_den,
  output logic       out_uncor,
  output logic       out_sync,
  output logic       out_lock,
  output logic       non_compliant
);
  localparam int CW = $clog2(PKT_LEN);
  localparam int MW = $clog2(MF_PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PKT_LEN - 1);
  localparam logic [CW-1:0] PAY  = CW'(PAY_LEN);
  localparam logic [MW-1:0] MLAST = MW'(MF_PERIOD - 1);

  logic [CW-1:0] pos_q, pos_d;
  logic          unc_hold_q, unc_now;
  logic          den_q, uncor_q, psync_q, mfs_q, clk_q, lock_q;
  logic          synced_q, nc_q;
  logic [MW-1:0] mf_cnt_q;
  logic          is_mf;

  assign pos_d   = in_sop ? '0 : (pos_q == LAST ? pos_q : pos_q + 1'b1);
  assign unc_now = in_sop ? in_uncor : unc_hold_q;
  assign is_mf   = in_sop && (in_data == MF_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= LAST;
      unc_hold_q <= 1'b0;
      out_data   <= '0;
      den_q      <= 1'b0;
      uncor_q    <= 1'b0;
      psync_q    <= 1'b0;
      mfs_q      <= 1'b0;
      clk_q      <= 1'b0;
    end else begin
      clk_q <= in_valid;
      if (in_valid) begin
        pos_q      <= pos_d;
        unc_hold_q <= unc_now;
        out_data   <= in_data;
        den_q      <= pos_d < PAY;
        uncor_q    <= unc_now && (pos_d < PAY);
        psync_q    <= in_sop;
        mfs_q      <= is_mf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= carrier_lock & frame_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      nc_q     <= 1'b0;
      mf_cnt_q <= '0;
    end else if (in_valid && in_sop) begin
      if (!synced_q) begin
        if (is_mf) begin
          synced_q <= 1'b1;
          mf_cnt_q <= '0;
        end
      end else if (is_mf) begin
        mf_cnt_q <= '0;
        nc_q     <= (mf_cnt_q != MLAST);
      end else begin
        mf_cnt_q <= mf_cnt_q + 1'b1;
        if (mf_cnt_q == MLAST) nc_q <= 1'b1;
      end
    end
  end

  assign out_clk       = clk_q ^ inv_clk;
  assign out_den       = den_q ^ inv_den;
  assign out_uncor     = uncor_q ^ inv_uncor;
  assign out_sync      = (sync_sel ? psync_q : mfs_q) ^ inv_sync;
  assign out_lock      = lock_q ^ inv_lock;
  assign non_compliant = nc_q;

  p_hold_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  p_sync_in_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    psync_q |-> den_q);
  p_uncor_in_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uncor_q |-> den_q);
  p_mfs_is_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mfs_q |-> psync_q);
  p_lock_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_lock && frame_sync) |=> lock_q);
  p_clk_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q |=> !clk_q);
  p_nc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_mf && synced_q && mf_cnt_q == MLAST) |=> !nc_q);
  p_sop_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |=> (pos_q == '0));
endmodule

// File: tb/ts_out_fmt_tb.sv
module ts_out_fmt_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_uncor = 0;
  logic [7:0] in_data = '0;
  logic carrier_lock = 0, frame_sync = 0, sync_sel = 1;
  logic inv_den = 0, inv_uncor = 0, inv_sync = 0, inv_lock = 0, inv_clk = 0;
  logic [7:0] out_data;
  logic out_clk, out_den, out_uncor, out_sync, out_lock, non_compliant;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ts_out_fmt u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit sop, input bit unc);
    @(negedge clk);
    in_valid = 1; in_sop = sop; in_data = d; in_uncor = unc;
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_uncor = 0;
  endtask

  task automatic send_pkt(input logic [7:0] first, input bit unc, input string tag);
    logic mf;
    mf = (first == 8'hB8);
    for (int p = 0; p < 204; p++) begin
      logic [7:0] d;
      logic e_den, e_unc, e_syn;
      d = (p == 0) ? first : 8'(p ^ 8'h3C);
      send_byte(d, p == 0, unc);
      e_den = (p < 188) ^ inv_den;
      e_unc = (unc && p < 188) ^ inv_uncor;
      e_syn = (sync_sel ? (p == 0) : (p == 0 && mf)) ^ inv_sync;
      chk(out_data == d, {tag, " R1 data"}, out_data, d);
      chk(out_den == e_den, {tag, " R2 den"}, out_den, e_den);
      chk(out_uncor == e_unc, {tag, " R4 uncor"}, out_uncor, e_unc);
      chk(out_sync == e_syn, {tag, " R3/R6 sync"}, out_sync, e_syn);
    end
  endtask

  task automatic t_reset;
    chk(out_den == 0 && out_uncor == 0 && out_sync == 0 && out_clk == 0, "R11 strobes idle",
        {out_den, out_uncor, out_sync, out_clk}, 0);
    chk(non_compliant == 0, "R11 nc", non_compliant, 0);
    chk(out_lock == 0, "R11 lock", out_lock, 0);
  endtask

  task automatic t_default;
    send_pkt(8'h47, 0, "default-correctable");
    send_pkt(8'h47, 1, "default-uncorrectable");
  endtask

  task automatic t_polarity;
    inv_den = 1; inv_uncor = 1; inv_sync = 1;
    send_pkt(8'h47, 0, "R5 inverted-correctable");
    send_pkt(8'h47, 1, "R5 inverted-uncorrectable");
    inv_uncor = 0; inv_sync = 0;
    send_pkt(8'h47, 1, "R5 only-den-inverted");
    inv_den = 0;
  endtask

  task automatic t_clock;
    send_byte(8'h11, 1, 0);
    chk(out_clk == 1, "R8 phase1", out_clk, 1);
    @(negedge clk);
    chk(out_clk == 0, "R8 phase2", out_clk, 0);
    inv_clk = 1;
    send_byte(8'h12, 0, 0);
    chk(out_clk == 0, "R8 inverted phase1", out_clk, 0);
    @(negedge clk);
    chk(out_clk == 1, "R8 inverted phase2", out_clk, 1);
    inv_clk = 0;
  endtask

  task automatic t_restart;
    for (int p = 0; p < 190; p++) send_byte(8'h22, p == 0, 0);
    chk(out_den == 0, "R10 pre-restart parity", out_den, 0);
    send_byte(8'h47, 1, 0);
    chk(out_den == 1 && out_sync == 1, "R10 restart", {out_den, out_sync}, 2'b11);
    send_byte(8'h01, 0, 0);
    chk(out_sync == 0 && out_den == 1, "R10 pos1", {out_den, out_sync}, 2'b10);
  endtask

  task automatic t_lock;
    logic [1:0] v;
    for (int i = 0; i < 8; i++) begin
      v = 2'(i);
      inv_lock = i[2];
      @(negedge clk);
      carrier_lock = v[1]; frame_sync = v[0];
      @(negedge clk);
      chk(out_lock == ((v[1] & v[0]) ^ inv_lock), "R7/R5 lock", out_lock, (v[1] & v[0]) ^ inv_lock);
    end
    inv_lock = 0;
  endtask

  task automatic t_multiframe;
    sync_sel = 0;
    send_pkt(8'hB8, 0, "R6 mf-start");
    for (int k = 0; k < 7; k++) send_pkt(8'h47, 0, "R6 plain");
    send_pkt(8'hB8, 0, "R6 mf-again");
    chk(non_compliant == 0, "R9 proper spacing", non_compliant, 0);
    for (int k = 0; k < 3; k++) send_pkt(8'h47, 0, "R9 short");
    send_pkt(8'hB8, 0, "R9 early");
    chk(non_compliant == 1, "R9 early mf", non_compliant, 1);
    for (int k = 0; k < 7; k++) send_pkt(8'h47, 0, "R9 fill");
    send_pkt(8'hB8, 0, "R9 recover");
    chk(non_compliant == 0, "R9 cleared", non_compliant, 0);
    for (int k = 0; k < 8; k++) send_pkt(8'h47, 0, "R9 missing");
    chk(non_compliant == 1, "R9 missing mf", non_compliant, 1);
    sync_sel = 1;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_default();
    t_polarity();
    t_clock();
    t_restart();
    t_lock();
    t_multiframe();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule